// File: doc/BRIEF.md
# Double-Ranked Crossbar Configuration Controller

This block holds the routing configuration of a nonblocking crossbar with 40 inputs and 40 outputs, one bit per lane, and applies it to a logical lane switch. Any output may take any input, and one input may feed any number of outputs. A host programs the block through a byte-wide parallel register port. The port has an active-low chip select, active-low write and read strobes, an 8-bit address, and separate 8-bit write and read data buses.

Programming is double-ranked. Host writes land only in a staging rank. An active-low update strobe then copies the whole staging rank into the active rank in a single clock, so every routing change takes effect together. Two complete connection maps are kept, and a map-select register picks the one that drives the switch. That register is also staged, so a map swap waits for the update strobe too. Each output lane has an enable bit and a polarity-invert bit.

All host signals are sampled on the rising edge of `clk`, which is the block clock. Reset is synchronous and active high.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: After reset, every lane output is 0 for any input pattern, and every address reads back 0x00.
- R2: A write is taken on the first clock at which `wr_n` is seen high after being low, and only if `cs_n` is low at that clock. A write strobe pulsed while `cs_n` is high leaves the staged contents unchanged.
- R3: Writes to the staging rank do not change the lane outputs until an update occurs.
- R4: The first clock at which `upd_n` is seen low after being high copies the entire staging rank (both maps, the map select and all polarity bits) into the active rank at once.
- R5: Each route entry is a byte: bit 7 is the enable and bits 6:0 are the source input number. When the entry is enabled and the source is 0 to 39, output j carries input `src`, and several outputs may share one source.
- R6: When bit 7 of a route entry is 0, or its source field is above 39, that output drives 0 regardless of its polarity bit.
- R7: Addresses 0x00+j and 0x28+j hold the route entry of output j in map 0 and map 1 respectively. Bit 0 of address 0x50 selects map 1 when set, and this select is itself staged until an update.
- R8: Addresses 0x58 to 0x5C hold the polarity bits. Output j is controlled by bit j mod 8 of address 0x58 + j/8, and a set bit inverts an enabled output.
- R9: When `cs_n` and `rd_n` are both low at a clock edge, `rd_data` shows the staged value at `addr` after that edge. Unmapped addresses and the unused bits 7:1 of 0x50 read as 0. When no read is being made, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low; write taken on its rising edge |
| rd_n | input | 1 | Host read strobe, active low |
| upd_n | input | 1 | Update strobe, active low; staging rank to active rank |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data of the staging rank |
| lane_in | input | 40 | Crossbar input lanes |
| lane_out | output | 40 | Crossbar output lanes |

## Verification
Lane outputs are combinational from the active rank and `lane_in`. The bench therefore changes `lane_in` at a falling edge and compares the outputs one nanosecond later. An update takes effect at the single rising edge between the falling edge that drives `upd_n` low and the next one, so routing checks are made at the next falling edge or later. The checks made just before that edge confirm that the old routing still holds. Read data is registered once: the bench applies the address and strobes at a falling edge and samples `rd_data` at the following falling edge. After releasing the strobes, it samples one more cycle to confirm that `rd_data` has returned to zero. A write commits at the rising edge that follows the release of `wr_n`, so readback starts only after that edge.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    // Route entry byte: bit 7 enable, bits 6:0 source input number
    typedef struct packed {
        logic       en;
        logic [6:0] src;
    } route_t;

    localparam int ROUTE_W = $bits(route_t);

    // A route is live when enabled and its source lies inside the lane range
    function automatic logic route_live(route_t r, logic [6:0] lim);
        return r.en && (r.src < lim);
    endfunction

endpackage

// File: rtl/xbar_host_port.sv
module xbar_host_port (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic upd_n,
    output logic wr_stb,
    output logic upd_stb,
    output logic rd_en
);
    logic wr_q;
    logic upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b1;
            upd_q <= 1'b1;
        end else begin
            wr_q  <= wr_n;
            upd_q <= upd_n;
        end
    end

    // Write commits on the low-to-high return of the write strobe
    assign wr_stb  = wr_n & ~wr_q & ~cs_n;
    // Update fires once on the high-to-low transition of its strobe
    assign upd_stb = ~upd_n & upd_q;
    assign rd_en   = ~cs_n & ~rd_n;

    // R4: an update strobe held low produces a single copy pulse
    assert_single_update_R4: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

endmodule

// File: rtl/xbar_cfg_ranks.sv
module xbar_cfg_ranks
    import xbar_cfg_pkg::*;
#(
    parameter int N_LANES   = 40,
    parameter int ADDR_W    = 8,
    parameter int MAP1_BASE = 40,
    parameter int SEL_ADDR  = 'h50,
    parameter int POL_BASE  = 'h58
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_stb,
    input  logic                       upd_stb,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ROUTE_W-1:0]         wr_data,
    output logic [ROUTE_W-1:0]         rd_data,
    output route_t [N_LANES-1:0]       act_m0,
    output route_t [N_LANES-1:0]       act_m1,
    output logic                       act_sel,
    output logic [N_LANES-1:0]         act_pol
);
    localparam int POL_REGS = (N_LANES + ROUTE_W - 1) / ROUTE_W;

    route_t [N_LANES-1:0] stg_m0;
    route_t [N_LANES-1:0] stg_m1;
    logic                 stg_sel;
    logic [N_LANES-1:0]   stg_pol;
    logic [ROUTE_W-1:0]   rd_val;

    // First rank: host writes
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_m0  <= '0;
            stg_m1  <= '0;
            stg_sel <= 1'b0;
            stg_pol <= '0;
        end else if (wr_stb) begin
            for (int i = 0; i < N_LANES; i++) begin
                if (addr == ADDR_W'(i))
                    stg_m0[i] <= route_t'(wr_data);
                if (addr == ADDR_W'(MAP1_BASE + i))
                    stg_m1[i] <= route_t'(wr_data);
            end
            if (addr == ADDR_W'(SEL_ADDR))
                stg_sel <= wr_data[0];
            for (int b = 0; b < N_LANES; b++) begin
                if (addr == ADDR_W'(POL_BASE + b / ROUTE_W))
                    stg_pol[b] <= wr_data[b % ROUTE_W];
            end
        end
    end

    // Second rank: whole-rank copy on update
    always_ff @(posedge clk) begin
        if (rst) begin
            act_m0  <= '0;
            act_m1  <= '0;
            act_sel <= 1'b0;
            act_pol <= '0;
        end else if (upd_stb) begin
            act_m0  <= stg_m0;
            act_m1  <= stg_m1;
            act_sel <= stg_sel;
            act_pol <= stg_pol;
        end
    end

    // Readback of the first rank
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_LANES; i++) begin
            if (addr == ADDR_W'(i))
                rd_val = stg_m0[i];
            if (addr == ADDR_W'(MAP1_BASE + i))
                rd_val = stg_m1[i];
        end
        if (addr == ADDR_W'(SEL_ADDR))
            rd_val[0] = stg_sel;
        for (int b = 0; b < N_LANES; b++) begin
            if (addr == ADDR_W'(POL_BASE + b / ROUTE_W))
                rd_val[b % ROUTE_W] = stg_pol[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_en ? rd_val : '0;
    end

    // R2: staged contents change only on an accepted write
    assert_stage_keep_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(stg_m0) && $stable(stg_m1) &&
                     $stable(stg_sel) && $stable(stg_pol)));

    // R3: active rank holds between updates
    assert_active_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> ($stable(act_m0) && $stable(act_m1) &&
                      $stable(act_sel) && $stable(act_pol)));

    // R4: an update leaves the active rank equal to the staged rank
    assert_rank_copy_R4: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> (act_m0 == $past(stg_m0) && act_m1 == $past(stg_m1) &&
                     act_sel == $past(stg_sel) && act_pol == $past(stg_pol)));

    // R9: read data returns to zero when no read is made
    assert_idle_read_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

endmodule

// File: rtl/xbar_lane_switch.sv
module xbar_lane_switch
    import xbar_cfg_pkg::*;
#(
    parameter int N_LANES = 40
) (
    input  route_t [N_LANES-1:0] routes,
    input  logic   [N_LANES-1:0] pol,
    input  logic   [N_LANES-1:0] lane_in,
    output logic   [N_LANES-1:0] lane_out
);
    localparam logic [6:0] LANE_LIM = 7'(N_LANES);

    for (genvar j = 0; j < N_LANES; j++) begin : g_out
        logic pick;

        always_comb begin
            pick = 1'b0;
            for (int i = 0; i < N_LANES; i++) begin
                if (routes[j].src == 7'(i))
                    pick = lane_in[i];
            end
        end

        assign lane_out[j] = route_live(routes[j], LANE_LIM) ? (pick ^ pol[j]) : 1'b0;
    end

endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
    import xbar_cfg_pkg::*;
#(
    parameter int N_LANES   = 40,
    parameter int ADDR_W    = 8,
    parameter int MAP1_BASE = 40,
    parameter int SEL_ADDR  = 'h50,
    parameter int POL_BASE  = 'h58
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic               rd_n,
    input  logic               upd_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic [N_LANES-1:0] lane_in,
    output logic [N_LANES-1:0] lane_out
);
    logic                 wr_stb;
    logic                 upd_stb;
    logic                 rd_en;
    route_t [N_LANES-1:0] act_m0;
    route_t [N_LANES-1:0] act_m1;
    route_t [N_LANES-1:0] act_routes;
    logic                 act_sel;
    logic [N_LANES-1:0]   act_pol;

    xbar_host_port u_port (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .upd_n   (upd_n),
        .wr_stb  (wr_stb),
        .upd_stb (upd_stb),
        .rd_en   (rd_en)
    );

    xbar_cfg_ranks #(
        .N_LANES   (N_LANES),
        .ADDR_W    (ADDR_W),
        .MAP1_BASE (MAP1_BASE),
        .SEL_ADDR  (SEL_ADDR),
        .POL_BASE  (POL_BASE)
    ) u_ranks (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .upd_stb (upd_stb),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .act_m0  (act_m0),
        .act_m1  (act_m1),
        .act_sel (act_sel),
        .act_pol (act_pol)
    );

    assign act_routes = act_sel ? act_m1 : act_m0;

    xbar_lane_switch #(
        .N_LANES (N_LANES)
    ) u_switch (
        .routes   (act_routes),
        .pol      (act_pol),
        .lane_in  (lane_in),
        .lane_out (lane_out)
    );

    // R1: the first cycle after reset leaves every output dark
    assert_reset_dark_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lane_out == '0);

endmodule

// File: tb/test_xbar_cfg_ctrl.sv
`timescale 1ns/1ps
module test_xbar_cfg_ctrl;
    localparam int N = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, upd_n = 1'b1;
    logic [7:0]   addr = '0, wr_data = '0;
    logic [7:0]   rd_data;
    logic [N-1:0] lane_in = '0;
    logic [N-1:0] lane_out;

    int checks = 0;
    int fails  = 0;

    // Bench model of both ranks
    logic [7:0]   st_m [2][N];
    logic [7:0]   ac_m [2][N];
    logic         st_sel, ac_sel;
    logic [N-1:0] st_pol, ac_pol;

    always #5 clk = ~clk;

    xbar_cfg_ctrl i_xbar_cfg_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .upd_n(upd_n), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .lane_in(lane_in), .lane_out(lane_out)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a < 8'd40)                    return st_m[0][a];
        if (a >= 8'd40 && a < 8'd80)      return st_m[1][a - 8'd40];
        if (a == 8'h50)                   return {7'b0, st_sel};
        if (a >= 8'h58 && a <= 8'h5C)     return st_pol[(a - 8'h58) * 8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [N-1:0] exp_out(input logic [N-1:0] x);
        logic [N-1:0] r;
        r = '0;
        for (int j = 0; j < N; j++) begin
            logic [7:0] e;
            e = ac_m[ac_sel][j];
            if (e[7] && e[6:0] < 7'd40)
                r[j] = x[e[6:0]] ^ ac_pol[j];
        end
        return r;
    endfunction

    task automatic chk8(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic chk_lanes(input string req, input logic [N-1:0] pat);
        @(negedge clk);
        lane_in = pat;
        #1;
        checks++;
        if (lane_out !== exp_out(pat)) begin
            fails++;
            $display("FAIL %s: in %010h got %010h expected %010h", req, pat, lane_out, exp_out(pat));
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        if (a < 8'd40)                     st_m[0][a] = d;
        else if (a < 8'd80)                st_m[1][a - 8'd40] = d;
        else if (a == 8'h50)               st_sel = d[0];
        else if (a >= 8'h58 && a <= 8'h5C) st_pol[(a - 8'h58) * 8 +: 8] = d;
    endtask

    task automatic wr_nocs(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk8(req, rd_data, exp_rd(a));
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic update();
        @(negedge clk);
        upd_n = 1'b0;
        @(negedge clk);
        upd_n = 1'b1;
        for (int m = 0; m < 2; m++)
            for (int j = 0; j < N; j++) ac_m[m][j] = st_m[m][j];
        ac_sel = st_sel;
        ac_pol = st_pol;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++)
            for (int j = 0; j < N; j++) begin st_m[m][j] = '0; ac_m[m][j] = '0; end
        st_sel = 1'b0; ac_sel = 1'b0; st_pol = '0; ac_pol = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: dark outputs and zero readback after reset
        chk_lanes("R1 reset outputs", {N{1'b1}});
        for (int a = 0; a < 256; a++) rd_chk("R1 reset readback", 8'(a));

        // R7: program both maps
        for (int j = 0; j < N; j++) begin
            wr(8'(j), 8'h80 | 8'((j * 7 + 3) % N));
            wr(8'(40 + j), 8'h80 | 8'(39 - j));
        end
        // R3: nothing reaches the lanes before update
        chk_lanes("R3 staged map not live", {N{1'b1}});
        for (int a = 0; a < 80; a++) rd_chk("R9 staged readback R7", 8'(a));
        // R9: strobes released, read data back to zero
        @(negedge clk);
        chk8("R9 idle read data", rd_data, 8'h00);

        // R4 R5: update, then walking-one sweep over every input
        update();
        for (int i = 0; i < N; i++) chk_lanes("R5 route walk R4", 40'(1) << i);
        chk_lanes("R5 mixed pattern", 40'hA5_C3_96_F0_1E);

        // R2: write without chip select is ignored
        wr_nocs(8'd5, 8'h81);
        rd_chk("R2 write without cs", 8'd5);
        update();
        chk_lanes("R2 no-cs write not routed", 40'hF0_F0_F0_F0_F0);

        // R5: fan-out of input 7 to several outputs
        for (int j = 10; j < 20; j++) wr(8'(j), 8'h87);
        update();
        chk_lanes("R5 fanout", 40'h00_00_00_00_80);
        chk_lanes("R5 fanout low", 40'hFF_FF_FF_FF_7F);

        // R6: disabled entry, source out of range, boundary source 39
        wr(8'd3, 8'h05);
        wr(8'd4, 8'h80 | 8'd45);
        wr(8'd6, 8'h80 | 8'd39);
        wr(8'd8, 8'hFF);
        update();
        chk_lanes("R6 disabled lanes", {N{1'b1}});
        chk_lanes("R6 disabled lanes zero in", {N{1'b0}});

        // R8: polarity bits, staged first
        wr(8'h58, 8'hFF);
        wr(8'h59, 8'hA5);
        wr(8'h5A, 8'h3C);
        wr(8'h5B, 8'h01);
        wr(8'h5C, 8'h80);
        for (int a = 8'h58; a <= 8'h5C; a++) rd_chk("R8 polarity readback", 8'(a));
        chk_lanes("R3 polarity staged only", 40'h12_34_56_78_9A);
        update();
        chk_lanes("R8 polarity ones", {N{1'b1}});
        chk_lanes("R8 polarity zeros", {N{1'b0}});
        chk_lanes("R8 polarity mixed", 40'h12_34_56_78_9A);

        // R7: map select staged until update
        wr(8'h50, 8'hFF);
        rd_chk("R7 select readback", 8'h50);
        chk_lanes("R7 select waits for update", 40'hC0_FF_EE_01_23);
        update();
        for (int i = 0; i < N; i += 5) chk_lanes("R7 map1 walk", 40'(1) << i);
        wr(8'h50, 8'h00);
        update();
        chk_lanes("R7 back to map0", 40'hC0_FF_EE_01_23);

        // R9: unmapped addresses
        rd_chk("R9 unmapped 0x51", 8'h51);
        rd_chk("R9 unmapped 0x5D", 8'h5D);
        rd_chk("R9 unmapped 0xFF", 8'hFF);

        // R1: reset again restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 2; m++)
            for (int j = 0; j < N; j++) begin st_m[m][j] = '0; ac_m[m][j] = '0; end
        st_sel = 1'b0; ac_sel = 1'b0; st_pol = '0; ac_pol = '0;
        chk_lanes("R1 second reset outputs", {N{1'b1}});
        rd_chk("R1 second reset readback", 8'd12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule